// File: doc/BRIEF.md
# Multiplexed SRAM Bus Target

This block lets a digital test environment stand in for an asynchronous memory whose address and data share one 16-bit bus. It samples the chip select, address-valid, output-enable, write-enable and two byte-enable strobes on a fast internal clock. It also samples five upper address pins and the shared bus. From these it works out the bus mode. It keeps the address that was present while address-valid was low and uses it for the whole access.

Reads return a stored word on the shared bus, with one output-enable bit for each byte lane. A write stores the data lanes that are enabled on the last sampled cycle before the write ends.

The storage is a small register file indexed by a few low bus bits and a few upper-pin bits. Higher address bits alias. A sticky flag reports a write-enable pulse held longer than a set number of cycles.

Top module: `muxsram_target`

## Requirements
- R1: After synchronous reset, `adq_oe` is 00, `we_err` is 0 and every stored word reads as 0000.
- R2: While the sampled chip select is high, no byte lane is driven, whatever the other strobes do.
- R3: While chip select and address-valid are both sampled low, the address register follows `{a_hi, adq_in}`. It holds its value once address-valid is high. The word index is `{a_hi[HI_W-1:0], adq_in[LO_W-1:0]}` (defaults 2 and 4 bits), so other address bits alias.
- R4: A read is chip select low, address-valid high, output-enable low and write-enable high. `adq_oe[0]` drives bits 7:0 when lower-enable is low. `adq_oe[1]` drives bits 15:8 when upper-enable is low. `adq_out` carries the stored word.
- R5: With chip select low and both output-enable and write-enable high, nothing is driven. Nothing is driven while address-valid is low.
- R6: A write is chip select low, address-valid high, write-enable low and at least one byte enable low. Output-enable has no effect on it, and nothing is driven during it.
- R7: A write ends when chip select goes high, write-enable goes high, or both byte enables go high. It stores only the data and lanes seen on the last sampled cycle of the write.
- R8: A pin change reaches `adq_oe` on the third rising clock edge after it, counting the two synchroniser stages.
- R9: `we_err` is set once write-enable has been sampled low for more than `WE_LIMIT` consecutive cycles. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| a_hi | input | 5 | Upper address pins |
| adq_in | input | 16 | Shared address/data bus, as seen from the pins |
| adq_out | output | 16 | Read data toward the shared bus |
| adq_oe | output | 2 | Drive enable per byte lane (bit 0 = bits 7:0) |
| we_err | output | 1 | Sticky flag for an over-long write-enable pulse |

## Verification
The assertions take it for granted that the strobes and the bus stay steady for at least two sample clocks around each edge. Without that, the two-flop synchroniser could let a half-changed bus word through as one sample. The stimulus changes pins only on the falling clock and holds each phase for four clocks. Address, data and byte enables are set in the same step as the strobe that qualifies them. Write-enable pulses are kept far below the limit, except in the one sequence that is meant to trip the error flag.

// File: rtl/muxsram_pkg.sv
// Shared types for the multiplexed SRAM bus target.
// Assumes a 16-bit shared bus split in two byte lanes and five upper address pins.
package muxsram_pkg;
    localparam int BUS_W   = 16;
    localparam int AHI_W   = 5;
    localparam int LANES   = BUS_W / 8;
    localparam int CTRL_W  = 6;
    localparam int PIN_W   = CTRL_W + AHI_W + BUS_W;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_ADDR  = 2'd1,
        MODE_READ  = 2'd2,
        MODE_WRITE = 2'd3
    } bus_mode_e;

    typedef struct packed {
        logic             cs_n;
        logic             adv_n;
        logic             oe_n;
        logic             we_n;
        logic             ub_n;
        logic             lb_n;
        logic [AHI_W-1:0] a_hi;
        logic [BUS_W-1:0] adq;
    } pins_t;

    localparam logic [PIN_W-1:0] PINS_IDLE = {{CTRL_W{1'b1}}, {(AHI_W + BUS_W){1'b0}}};
endpackage

// File: rtl/muxsram_sync.sv
// Two-flop synchroniser for a vector of asynchronous pins.
// Assumes multi-bit groups are held steady by the bus master long enough
// that a skewed sample cannot be taken as a valid word.
module muxsram_sync #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/muxsram_decode.sv
// Mode decoder: latches the access address, tracks an active write and
// emits a one-cycle commit when the write ends, plus read lane enables.
// Assumes its inputs are already synchronised.
module muxsram_decode
    import muxsram_pkg::*;
#(
    parameter int LO_W = 4,
    parameter int HI_W = 2,
    localparam int IDX_W = LO_W + HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pins_t            s,
    output logic [IDX_W-1:0] idx_q,
    output logic             commit,
    output logic [LANES-1:0] commit_be,
    output logic [BUS_W-1:0] commit_data,
    output logic [LANES-1:0] rd_lanes
);
    bus_mode_e        mode;
    logic             wr_live;
    logic             pend_q;
    logic [LANES-1:0] be_q;
    logic [BUS_W-1:0] data_q;
    logic [LANES-1:0] lane_en;

    assign lane_en = ~{s.ub_n, s.lb_n};

    // Decode the bus mode from the strobes; a write outranks a read.
    always_comb begin
        if (s.cs_n)       mode = MODE_IDLE;
        else if (!s.adv_n) mode = MODE_ADDR;
        else if (!s.we_n)  mode = MODE_WRITE;
        else if (!s.oe_n)  mode = MODE_READ;
        else               mode = MODE_IDLE;
    end

    assign wr_live = (mode == MODE_WRITE) && (lane_en != '0);

    // Follow the address bus while address-valid is low; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)               idx_q <= '0;
        else if (mode == MODE_ADDR) idx_q <= {s.a_hi[HI_W-1:0], s.adq[LO_W-1:0]};
    end

    // Capture data and lanes on each live write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            be_q   <= '0;
            data_q <= '0;
        end else if (wr_live) begin
            pend_q <= 1'b1;
            be_q   <= lane_en;
            data_q <= s.adq;
        end else begin
            pend_q <= 1'b0;
        end
    end

    assign commit      = pend_q && !wr_live;
    assign commit_be   = be_q;
    assign commit_data = data_q;
    assign rd_lanes    = (mode == MODE_READ) ? lane_en : '0;
endmodule

// File: rtl/muxsram_mem.sv
// Byte-lane register file: one array per lane, synchronous write with a
// lane strobe, combinational read. Cleared by reset.
module muxsram_mem
    import muxsram_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LANES-1:0] be,
    input  logic [IDX_W-1:0] idx,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] cells [DEPTH];

        // Store this lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
            end else if (we && be[l]) begin
                cells[idx] <= wdata[l*8 +: 8];
            end
        end

        assign rdata[l*8 +: 8] = cells[idx];
    end
endmodule

// File: rtl/muxsram_we_guard.sv
// Counts consecutive sampled-low cycles of write-enable and raises a
// sticky flag once the count exceeds the limit. Reset alone clears it.
module muxsram_we_guard #(
    parameter int WE_LIMIT = 500,
    localparam int CW = $clog2(WE_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n_s,
    output logic err
);
    logic [CW-1:0] run_q;

    // Saturating run-length counter and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            err   <= 1'b0;
        end else if (we_n_s) begin
            run_q <= '0;
        end else begin
            if (run_q == CW'(WE_LIMIT)) err <= 1'b1;
            else                        run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/muxsram_target.sv
// Top of the multiplexed SRAM bus target. Synchronises the pins, decodes
// the access, stores writes in a byte-lane register file and registers
// read data and lane enables toward the shared bus.
// Assumes the master holds each bus phase for at least two clocks.
module muxsram_target
    import muxsram_pkg::*;
#(
    parameter int LO_W     = 4,
    parameter int HI_W     = 2,
    parameter int WE_LIMIT = 500,
    localparam int IDX_W   = LO_W + HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             adv_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic             ub_n,
    input  logic             lb_n,
    input  logic [AHI_W-1:0] a_hi,
    input  logic [BUS_W-1:0] adq_in,
    output logic [BUS_W-1:0] adq_out,
    output logic [LANES-1:0] adq_oe,
    output logic             we_err
);
    pins_t            raw_pins;
    pins_t            s_pins;
    logic [IDX_W-1:0] idx_q;
    logic             mem_we;
    logic [LANES-1:0] mem_be;
    logic [BUS_W-1:0] mem_wdata;
    logic [BUS_W-1:0] mem_rdata;
    logic [LANES-1:0] rd_lanes;

    assign raw_pins = '{cs_n: cs_n, adv_n: adv_n, oe_n: oe_n, we_n: we_n,
                        ub_n: ub_n, lb_n: lb_n, a_hi: a_hi, adq: adq_in};

    muxsram_sync #(.W(PIN_W), .RST_VAL(PINS_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(s_pins)
    );

    muxsram_decode #(.LO_W(LO_W), .HI_W(HI_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .s(s_pins), .idx_q(idx_q),
        .commit(mem_we), .commit_be(mem_be), .commit_data(mem_wdata),
        .rd_lanes(rd_lanes)
    );

    muxsram_mem #(.IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .be(mem_be), .idx(idx_q),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    muxsram_we_guard #(.WE_LIMIT(WE_LIMIT)) u_guard (
        .clk(clk), .rst_n(rst_n), .we_n_s(s_pins.we_n), .err(we_err)
    );

    // Register read data and lane enables toward the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adq_out <= '0;
            adq_oe  <= '0;
        end else begin
            adq_out <= mem_rdata;
            adq_oe  <= rd_lanes;
        end
    end
endmodule

// File: rtl/muxsram_target_chk.sv
// Assertion checker for muxsram_target, attached by bind below.
module muxsram_target_chk
    import muxsram_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input pins_t            s_pins,
    input logic [IDX_W-1:0] idx_q,
    input logic             mem_we,
    input logic [LANES-1:0] adq_oe,
    input logic             we_err
);
    logic wr_window;
    logic rd_window;
    assign wr_window = !s_pins.cs_n && s_pins.adv_n && !s_pins.we_n && !(s_pins.ub_n && s_pins.lb_n);
    assign rd_window = !s_pins.cs_n && s_pins.adv_n && !s_pins.oe_n && s_pins.we_n;

    p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_pins.cs_n |=> adq_oe == '0);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_pins.adv_n |=> $stable(idx_q));

    p_read_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_window |=> adq_oe == ~$past({s_pins.ub_n, s_pins.lb_n}));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_pins.oe_n && s_pins.we_n) || !s_pins.adv_n |=> adq_oe == '0);

    p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_pins.cs_n && !s_pins.we_n) |=> adq_oe == '0);

    p_commit_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wr_window);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we_err |=> we_err);
endmodule

bind muxsram_target muxsram_target_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_pins(s_pins), .idx_q(idx_q),
    .mem_we(mem_we), .adq_oe(adq_oe), .we_err(we_err)
);

// File: tb/muxsram_target_test.sv
`timescale 1ns/1ps
module muxsram_target_test;
    localparam int LIMIT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [4:0]  a_hi = '0;
    logic [15:0] adq_in = '0;
    logic [15:0] adq_out;
    logic [1:0]  adq_oe;
    logic        we_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] data;
        logic [1:0]  lanes;
        string       req;
    } exp_t;
    exp_t exp_q[$];
    event sample_ev;

    always #2.5 clk = ~clk;

    muxsram_target #(.WE_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
        .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n), .a_hi(a_hi), .adq_in(adq_in),
        .adq_out(adq_out), .adq_oe(adq_oe), .we_err(we_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_idle();
        cs_n = 1; adv_n = 1; oe_n = 1; we_n = 1; ub_n = 1; lb_n = 1;
        settle(4);
    endtask

    task automatic put_addr(input logic [4:0] hi, input logic [15:0] lo);
        cs_n = 0; adv_n = 0; a_hi = hi; adq_in = lo;
        settle(4);
        adv_n = 1;
    endtask

    task automatic bus_write(input logic [4:0] hi, input logic [15:0] lo, input logic [15:0] d,
                             input logic ub, input logic lb, input logic oe);
        put_addr(hi, lo);
        adq_in = d; ub_n = ub; lb_n = lb; oe_n = oe; we_n = 0;
        settle(4);
        we_n = 1;
        settle(2);
        go_idle();
    endtask

    // Driver: performs a read and pushes the expected result for the monitor.
    task automatic bus_read(input logic [4:0] hi, input logic [15:0] lo, input logic ub, input logic lb,
                            input logic [15:0] d, input string req);
        exp_t e;
        put_addr(hi, lo);
        adq_in = 16'hDEAD; ub_n = ub; lb_n = lb; oe_n = 0;
        settle(4);
        e.data = d; e.lanes = ~{ub, lb}; e.req = req;
        exp_q.push_back(e);
        -> sample_ev;
        settle(1);
        go_idle();
    endtask

    // Monitor: pops expected reads and compares the driven lanes.
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() != 0) begin
                exp_t e;
                logic [15:0] m;
                e = exp_q.pop_front();
                m = {{8{e.lanes[1]}}, {8{e.lanes[0]}}};
                check(adq_oe == e.lanes, e.req, {30'd0, adq_oe}, {30'd0, e.lanes});
                check((adq_out & m) == (e.data & m), e.req, {16'd0, adq_out & m}, {16'd0, e.data & m});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1;
        settle(1);
        // R1: reset state
        check(adq_oe == 2'b00, "R1", {30'd0, adq_oe}, 0);
        check(we_err == 1'b0, "R1", {31'd0, we_err}, 0);
        bus_read(5'd0, 16'h0005, 0, 0, 16'h0000, "R1");

        // R6/R4: word write then lane reads
        bus_write(5'd0, 16'h0005, 16'h1234, 0, 0, 1);
        bus_read(5'd0, 16'h0005, 0, 0, 16'h1234, "R4");
        bus_read(5'd0, 16'h0005, 1, 0, 16'h1234, "R4");
        bus_read(5'd0, 16'h0005, 0, 1, 16'h1234, "R4");

        // R6: lower-only write, then upper-only write with OE low
        bus_write(5'd0, 16'h0005, 16'hBEEF, 1, 0, 1);
        bus_read(5'd0, 16'h0005, 0, 0, 16'h12EF, "R6");
        put_addr(5'd0, 16'h0005);
        adq_in = 16'h77CC; ub_n = 0; lb_n = 1; oe_n = 0; we_n = 0;
        settle(4);
        check(adq_oe == 2'b00, "R6", {30'd0, adq_oe}, 0);
        we_n = 1; settle(2); go_idle();
        bus_read(5'd0, 16'h0005, 0, 0, 16'h77EF, "R6");

        // R3: aliasing of address bits beyond the index
        bus_write(5'd1, 16'h0013, 16'hA5C3, 0, 0, 1);
        bus_read(5'b10101, 16'hAB03, 0, 0, 16'hA5C3, "R3");
        bus_read(5'd0, 16'h0003, 0, 0, 16'h0000, "R3");

        // R7: lanes and data from the last write cycle
        put_addr(5'd0, 16'h0009);
        adq_in = 16'h1111; ub_n = 0; lb_n = 0; we_n = 0;
        settle(4);
        adq_in = 16'h2299; ub_n = 1;
        settle(4);
        we_n = 1; settle(2); go_idle();
        bus_read(5'd0, 16'h0009, 0, 0, 16'h0099, "R7");

        // R7: write ended by chip select
        put_addr(5'd0, 16'h000A);
        adq_in = 16'hC0DE; ub_n = 0; lb_n = 0; we_n = 0;
        settle(4);
        cs_n = 1; settle(2); go_idle();
        bus_read(5'd0, 16'h000A, 0, 0, 16'hC0DE, "R7");

        // R7: write ended by both byte enables
        put_addr(5'd0, 16'h000B);
        adq_in = 16'hF00D; ub_n = 0; lb_n = 0; we_n = 0;
        settle(4);
        ub_n = 1; lb_n = 1; settle(2);
        adq_in = 16'h0000; settle(2); go_idle();
        bus_read(5'd0, 16'h000B, 0, 0, 16'hF00D, "R7");

        // R5: output disabled, and address phase with OE low
        put_addr(5'd0, 16'h0005);
        ub_n = 0; lb_n = 0; settle(4);
        check(adq_oe == 2'b00, "R5", {30'd0, adq_oe}, 0);
        adv_n = 0; oe_n = 0; settle(4);
        check(adq_oe == 2'b00, "R5", {30'd0, adq_oe}, 0);
        go_idle();

        // R2: deselected with read strobes low
        cs_n = 1; adv_n = 1; oe_n = 0; we_n = 1; ub_n = 0; lb_n = 0;
        settle(4);
        check(adq_oe == 2'b00, "R2", {30'd0, adq_oe}, 0);
        go_idle();

        // R8: latency of drive and release
        put_addr(5'd0, 16'h0005);
        ub_n = 0; lb_n = 0; settle(4);
        oe_n = 0;
        settle(2);
        check(adq_oe == 2'b00, "R8", {30'd0, adq_oe}, 0);
        settle(1);
        check(adq_oe == 2'b11, "R8", {30'd0, adq_oe}, 3);
        oe_n = 1;
        settle(2);
        check(adq_oe == 2'b11, "R8", {30'd0, adq_oe}, 3);
        settle(1);
        check(adq_oe == 2'b00, "R8", {30'd0, adq_oe}, 0);
        go_idle();

        // R9: short pulse keeps flag clear, long pulse sets it, flag sticks
        we_n = 0; settle(10); we_n = 1; settle(4);
        check(we_err == 1'b0, "R9", {31'd0, we_err}, 0);
        we_n = 0; settle(24); we_n = 1; settle(4);
        check(we_err == 1'b1, "R9", {31'd0, we_err}, 1);
        settle(8);
        check(we_err == 1'b1, "R9", {31'd0, we_err}, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule